// File: doc/BRIEF.md
# NaN-Boxed Single-Precision Sign Injection Unit

This unit sits beside a 64-bit floating-point register file and executes the three single-precision sign-injection operations in one cycle: plain injection, negated injection and xor injection. A 32-bit value held in a 64-bit register is only legal when its upper half is all ones (NaN-boxed). The unit validates each source operand and substitutes the boxed canonical quiet NaN for any operand that fails the check. It then splices the new sign bit into operand 1 and always returns a boxed result.

When the issuing logic reports that both source register numbers are equal, operand 2 is disregarded. Plain injection then becomes a register move, negated injection becomes a negate and xor injection becomes an absolute value. The result is available combinationally. A registered copy with a one-cycle valid strobe is also provided for pipelines that want the value at the next stage boundary.

Top module: `nanbox_sgnj`

## Requirements
- R1: An operand whose bits 63:32 are all ones is used unchanged by the operation.
- R2: An operand whose bits 63:32 are not all ones is replaced by 0xFFFFFFFF7FC00000 before the sign manipulation.
- R3: Operation code 2'b00 (plain) returns bits 30:0 of checked operand 1 with bit 31 taken from checked operand 2.
- R4: Operation code 2'b01 (negated) returns bits 30:0 of checked operand 1 with bit 31 equal to the inverse of checked operand 2's bit 31.
- R5: Operation code 2'b10 (xor) returns bits 30:0 of checked operand 1 with bit 31 equal to the xor of both checked operands' bit 31.
- R6: With the equal-source flag high, operand 2 has no effect on the result: code 00 moves checked operand 1, code 01 inverts its bit 31, code 10 clears its bit 31.
- R7: Operation code 2'b11 returns 0xFFFFFFFF7FC00000.
- R8: Bits 63:32 of every result are all ones.
- R9: One cycle after a cycle with the input strobe high, the registered result equals the combinational result of that cycle and the output strobe is high; the output strobe is low one cycle after a cycle with the input strobe low, and low after reset.
- R10: The registered result is zero after reset and holds its value across cycles with the input strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_vld_i | input | 1 | Input strobe; captures the result into the output register |
| src_a_i | input | 64 | Operand 1 (supplies magnitude and exponent) |
| src_b_i | input | 64 | Operand 2 (supplies sign information) |
| op_i | input | 2 | 00 plain, 01 negated, 10 xor, 11 canonical NaN |
| same_reg_i | input | 1 | Both source register numbers are equal |
| res_o | output | 64 | Combinational boxed result |
| res_q_o | output | 64 | Registered result |
| res_vld_o | output | 1 | Registered result valid, one cycle after in_vld_i |

## Verification
The bench builds the unit with its default parameters: a 64-bit register width, a 32-bit narrow format and an 8-bit exponent, so the canonical NaN is the boxed value 0xFFFFFFFF7FC00000. Those values put the box boundary exactly at 0xFFFFFFFF00000000, so operands one below it (0xFFFFFFFEFFFFFFFF) and single-bit holes in the upper half are reachable as rejected inputs, alongside legal operands with either sign. The directed scenarios combine both operands being rejected, the equal-source flag with a conflicting operand 2, and strobe gaps on the registered path.

// File: rtl/nbsj_pkg.sv
package nbsj_pkg;

   typedef enum logic [1:0] {
      SGNJ_PLAIN = 2'b00,
      SGNJ_NEG   = 2'b01,
      SGNJ_XOR   = 2'b10,
      SGNJ_RSVD  = 2'b11
   } sgnj_op_e;

endpackage

// File: rtl/nbsj_unbox.sv
module nbsj_unbox #(
   parameter int FLEN  = 64,
   parameter int NLEN  = 32,
   parameter int EXP_W = 8
) (
   input  logic [FLEN-1:0] raw_i,
   output logic [FLEN-1:0] chk_o
);
   localparam int BOX_W = FLEN - NLEN;
   localparam int MAN_W = NLEN - EXP_W - 1;
   localparam logic [FLEN-1:0] CNAN =
      {{BOX_W{1'b1}}, 1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic boxed;

   always_comb begin
      boxed = &raw_i[FLEN-1:NLEN];
      chk_o = boxed ? raw_i : CNAN;
   end
endmodule

// File: rtl/nbsj_inject.sv
module nbsj_inject
   import nbsj_pkg::*;
#(
   parameter int FLEN  = 64,
   parameter int NLEN  = 32,
   parameter int EXP_W = 8
) (
   input  logic [FLEN-1:0] a_i,
   input  logic [FLEN-1:0] b_i,
   input  sgnj_op_e        op_i,
   input  logic            same_i,
   output logic [FLEN-1:0] res_o
);
   localparam int BOX_W = FLEN - NLEN;
   localparam int SGN   = NLEN - 1;
   localparam int MAN_W = NLEN - EXP_W - 1;
   localparam logic [FLEN-1:0] CNAN =
      {{BOX_W{1'b1}}, 1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic sgn_a, sgn_b, sgn_new;

   always_comb begin
      sgn_a = a_i[SGN];
      // with equal sources operand 2 is never looked at
      sgn_b = same_i ? a_i[SGN] : b_i[SGN];
      unique case (op_i)
         SGNJ_PLAIN: sgn_new = sgn_b;
         SGNJ_NEG:   sgn_new = ~sgn_b;
         SGNJ_XOR:   sgn_new = sgn_a ^ sgn_b;
         default:    sgn_new = 1'b0;
      endcase
      if (op_i == SGNJ_RSVD)
         res_o = CNAN;
      else
         res_o = {{BOX_W{1'b1}}, sgn_new, a_i[SGN-1:0]};
   end
endmodule

// File: rtl/nbsj_outreg.sv
module nbsj_outreg #(
   parameter int W = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         vld_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic         vld_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_o   <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) q_o <= d_i;
      end
   end

   // R9
   vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o == $past(vld_i));
   // R9
   capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_i |=> q_o == $past(d_i));
   // R10
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_i |=> $stable(q_o));
endmodule

// File: rtl/nanbox_sgnj.sv
module nanbox_sgnj
   import nbsj_pkg::*;
#(
   parameter int FLEN  = 64,
   parameter int NLEN  = 32,
   parameter int EXP_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            in_vld_i,
   input  logic [FLEN-1:0] src_a_i,
   input  logic [FLEN-1:0] src_b_i,
   input  logic [1:0]      op_i,
   input  logic            same_reg_i,
   output logic [FLEN-1:0] res_o,
   output logic [FLEN-1:0] res_q_o,
   output logic            res_vld_o
);
   localparam int SGN = NLEN - 1;

   if (FLEN <= NLEN) begin : g_bad_flen
      $error("FLEN must exceed NLEN");
   end
   if (EXP_W < 2 || EXP_W > NLEN - 3) begin : g_bad_exp
      $error("EXP_W out of range");
   end

   logic [FLEN-1:0] raw  [2];
   logic [FLEN-1:0] chk  [2];

   assign raw[0] = src_a_i;
   assign raw[1] = src_b_i;

   for (genvar g = 0; g < 2; g++) begin : g_unbox
      nbsj_unbox #(.FLEN(FLEN), .NLEN(NLEN), .EXP_W(EXP_W)) i_unbox (
         .raw_i (raw[g]),
         .chk_o (chk[g])
      );
   end

   nbsj_inject #(.FLEN(FLEN), .NLEN(NLEN), .EXP_W(EXP_W)) i_inject (
      .a_i    (chk[0]),
      .b_i    (chk[1]),
      .op_i   (sgnj_op_e'(op_i)),
      .same_i (same_reg_i),
      .res_o  (res_o)
   );

   nbsj_outreg #(.W(FLEN)) i_outreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (in_vld_i),
      .d_i    (res_o),
      .q_o    (res_q_o),
      .vld_o  (res_vld_o)
   );

   // R8
   boxed_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      &res_o[FLEN-1:NLEN]);
   // R1
   low_bits_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&src_a_i[FLEN-1:NLEN] && op_i != 2'b11) |-> res_o[SGN-1:0] == src_a_i[SGN-1:0]);
   // R6
   abs_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (same_reg_i && op_i == 2'b10) |-> !res_o[SGN]);
   // R4
   neg_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 2'b01 && &src_b_i[FLEN-1:NLEN] && !same_reg_i) |-> res_o[SGN] != src_b_i[SGN]);
endmodule

// File: tb/test_nanbox_sgnj.sv
`timescale 1ns/1ps
module test_nanbox_sgnj;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [63:0] a = '0, b = '0;
   logic [1:0]  op = 2'b00;
   logic        same = 1'b0;
   logic [63:0] res, res_q;
   logic        res_vld;

   int n_chk = 0, n_fail = 0, cyc = 0;

   localparam logic [63:0] QNAN = 64'hFFFF_FFFF_7FC0_0000;

   always #2.5 clk = ~clk;

   nanbox_sgnj i_nanbox_sgnj (
      .clk_i(clk), .rst_ni(rst_n), .in_vld_i(vld), .src_a_i(a), .src_b_i(b),
      .op_i(op), .same_reg_i(same), .res_o(res), .res_q_o(res_q), .res_vld_o(res_vld)
   );

   function automatic logic [63:0] unbox(input logic [63:0] x);
      return (x >= 64'hFFFF_FFFF_0000_0000) ? x : QNAN;
   endfunction

   function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y,
                                         input logic [1:0] o, input logic s);
      logic [63:0] ca, cb;
      logic        sb;
      ca = unbox(x);
      cb = s ? ca : unbox(y);
      sb = cb[31];
      case (o)
         2'b00:   return 64'hFFFF_FFFF_0000_0000 | (ca & 64'h7FFF_FFFF) | ({63'd0, sb} << 31);
         2'b01:   return 64'hFFFF_FFFF_0000_0000 | (ca & 64'h7FFF_FFFF) | ({63'd0, ~sb} << 31);
         2'b10:   return 64'hFFFF_FFFF_0000_0000 | (ca & 64'h7FFF_FFFF) | ({63'd0, ca[31] ^ sb} << 31);
         default: return QNAN;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, sample combinational output 1 ns later
   task automatic apply(input string req, input logic [63:0] x, input logic [63:0] y,
                        input logic [1:0] o, input logic s);
      @(negedge clk);
      a = x; b = y; op = o; same = s;
      #1;
      chk(req, res, model(x, y, o, s));
      chk("R8", {32'd0, res[63:32]}, 64'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      chk("R10 reset q", res_q, 64'd0);
      chk("R9 reset vld", {63'd0, res_vld}, 64'd0);
   endtask

   task automatic t_plain();
      apply("R3 R1 plain pos<-neg", 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_C000_0000, 2'b00, 1'b0);
      chk("R3 value", res, 64'hFFFF_FFFF_BF80_0000);
      apply("R3 plain neg<-pos", 64'hFFFF_FFFF_C120_0000, 64'hFFFF_FFFF_0000_0001, 2'b00, 1'b0);
   endtask

   task automatic t_neg();
      apply("R4 neg", 64'hFFFF_FFFF_4049_0FDB, 64'hFFFF_FFFF_0000_0000, 2'b01, 1'b0);
      chk("R4 value", res, 64'hFFFF_FFFF_C049_0FDB);
      apply("R4 neg of neg", 64'hFFFF_FFFF_4049_0FDB, 64'hFFFF_FFFF_8000_0000, 2'b01, 1'b0);
   endtask

   task automatic t_xor();
      apply("R5 xor 1^1", 64'hFFFF_FFFF_8000_1234, 64'hFFFF_FFFF_8765_4321, 2'b10, 1'b0);
      chk("R5 value", res, 64'hFFFF_FFFF_0000_1234);
      apply("R5 xor 0^1", 64'hFFFF_FFFF_0000_1234, 64'hFFFF_FFFF_8000_0000, 2'b10, 1'b0);
   endtask

   task automatic t_badbox();
      apply("R2 bad a", 64'hFFFF_FFFE_FFFF_FFFF, 64'hFFFF_FFFF_8000_0000, 2'b00, 1'b0);
      chk("R2 value", res, 64'hFFFF_FFFF_FFC0_0000);
      apply("R2 bad b", 64'hFFFF_FFFF_BF80_0000, 64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b0);
      chk("R2 b value", res, 64'hFFFF_FFFF_3F80_0000);
      apply("R2 both bad neg", 64'h0000_0000_3F80_0000, 64'hFFEF_FFFF_0000_0000, 2'b01, 1'b0);
      chk("R2 both value", res, 64'hFFFF_FFFF_FFC0_0000);
   endtask

   task automatic t_same();
      apply("R6 move", 64'hFFFF_FFFF_BF80_0000, 64'hFFFF_FFFF_0000_0000, 2'b00, 1'b1);
      chk("R6 move value", res, 64'hFFFF_FFFF_BF80_0000);
      apply("R6 negate", 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_8000_0000, 2'b01, 1'b1);
      chk("R6 negate value", res, 64'hFFFF_FFFF_BF80_0000);
      apply("R6 abs", 64'hFFFF_FFFF_BF80_0000, 64'hFFFF_FFFF_8000_0000, 2'b10, 1'b1);
      chk("R6 abs value", res, 64'hFFFF_FFFF_3F80_0000);
      apply("R6 move bad", 64'h1234_5678_BF80_0000, 64'hFFFF_FFFF_8000_0000, 2'b00, 1'b1);
      chk("R6 move bad value", res, QNAN);
   endtask

   task automatic t_rsvd();
      apply("R7 code 11", 64'hFFFF_FFFF_BF80_0000, 64'hFFFF_FFFF_8000_0000, 2'b11, 1'b0);
      chk("R7 value", res, QNAN);
   endtask

   task automatic t_regout();
      logic [63:0] exp1;
      exp1 = model(64'hFFFF_FFFF_1111_1111, 64'hFFFF_FFFF_8000_0000, 2'b00, 1'b0);
      @(negedge clk);
      a = 64'hFFFF_FFFF_1111_1111; b = 64'hFFFF_FFFF_8000_0000; op = 2'b00; same = 1'b0;
      vld = 1'b1;
      @(negedge clk);
      chk("R9 q", res_q, exp1);
      chk("R9 vld high", {63'd0, res_vld}, 64'd1);
      vld = 1'b0;
      a = 64'hFFFF_FFFF_2222_2222; op = 2'b01;
      @(negedge clk);
      chk("R10 hold", res_q, exp1);
      chk("R9 vld low", {63'd0, res_vld}, 64'd0);
      @(negedge clk);
      chk("R10 hold 2", res_q, exp1);
      vld = 1'b1;
      @(negedge clk);
      chk("R9 q second", res_q, model(64'hFFFF_FFFF_2222_2222, 64'hFFFF_FFFF_8000_0000, 2'b01, 1'b0));
      vld = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_plain();
      t_neg();
      t_xor();
      t_badbox();
      t_same();
      t_rsvd();
      t_regout();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule